// File: doc/BRIEF.md
# Inbound Index Register Mailbox

This block is a window of inbound message words that an external bus master fills in. The host side reaches the window at byte offsets 0x050 to 0xFFF. Each host write lands in a backing array of 1004 words and also raises the index interrupt towards the local processor. The byte address of the first such write is held in a capture register, so firmware can see which word was hit. That capture stays frozen until firmware clears the status bit, which arms it again.

The host side is a valid/ready request channel with a registered read response channel. A request is taken on a cycle where `h_valid` and `h_ready` are both high. `h_ready` is low only while a read response is waiting and `h_rready` is low. A waiting response holds its data unchanged until the cycle in which `h_rready` is high. Host read bursts are a string of back-to-back read requests. The local processor has a plain word-addressed port with one cycle of read latency. It also has a write-one-to-clear strobe for the status bit and a mask input that gates the interrupt pin.

Top module: `mbx_index_mailbox`

## Requirements
- R1: An accepted host write with `h_addr[1:0]==0` and word address (`h_addr[11:2]`) in 20..1023 stores `h_wdata`. Later host or local reads of that word return the stored value.
- R2: That host write sets `irq_status` at the clock edge where the request is accepted.
- R3: If `irq_status` is clear, or `stat_w1c` is high in the same cycle, that host write loads its full byte address into `idx_addr`.
- R4: While `irq_status` is set and no clear is present, further host writes update storage but leave `idx_addr` unchanged.
- R5: `stat_w1c` clears `irq_status` on the next edge. When it coincides with a host write into the window, the set wins and the new address is captured.
- R6: Local writes into the window never set `irq_status` and never change `idx_addr`.
- R7: `irq` is high exactly when `irq_status` is set and `irq_mask` is low. The mask does not stop status setting or address capture.
- R8: Host writes that are unaligned or outside the window change neither storage, `irq_status` nor `idx_addr`. Host reads outside the window return zero.
- R9: When the host and the local side write the same word in the same cycle, the host data is stored.
- R10: A host read response appears with `h_rvalid` on the edge after acceptance. While `h_rvalid` is high and `h_rready` is low, `h_ready` is low and `h_rdata` holds.
- R11: After reset `irq_status`, `idx_addr`, `irq`, `h_rvalid` and `l_rdata` are zero.
- R12: A local read (`l_en` high, `l_we` low) presents the word on `l_rdata` one edge later and then holds it. Reads outside the window give zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request ready |
| h_write | input | 1 | 1 = write request, 0 = read request |
| h_addr | input | 12 | Host byte offset within the inbound space |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Host read response valid |
| h_rready | input | 1 | Host read response ready |
| h_rdata | output | 32 | Host read response data |
| l_en | input | 1 | Local access strobe |
| l_we | input | 1 | Local write when high, read when low |
| l_word | input | 10 | Local word address |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, one cycle after the strobe |
| stat_w1c | input | 1 | Local write of one to the index status bit |
| irq_mask | input | 1 | Suppresses `irq` when high |
| irq_status | output | 1 | Index interrupt status bit |
| idx_addr | output | 12 | Byte address of the captured host write |
| irq | output | 1 | Interrupt to the local processor |

## Verification
The properties assume that every input carries a known value on each edge after reset. They also assume `stat_w1c` is a strobe that the local side raises for single events. They do not assume that the host keeps a request up until it is accepted. The window check in the properties treats any request taken while `h_ready` is high as accepted. The bench drives only defined values, one edge after each clock rise, and drops `h_valid` freely. This covers both a well-behaved master and one that withdraws requests. Its random address pool deliberately straddles the lower window edge and includes the top word and unaligned offsets.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    HOP_IDLE  = 2'd0,
    HOP_STORE = 2'd1,
    HOP_FETCH = 2'd2,
    HOP_DROP  = 2'd3
  } hop_e;

  function automatic hop_e classify(input logic take, input logic wr,
                                    input logic aligned, input logic in_win);
    if (!take)                 return HOP_IDLE;
    if (!wr)                   return HOP_FETCH;
    if (aligned && in_win)     return HOP_STORE;
    return HOP_DROP;
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int WORD_W  = 10,
  parameter int LO_WORD = 20,
  parameter int HI_WORD = 1023
) (
  input  logic [WORD_W-1:0] word,
  output logic              in_win,
  output logic [WORD_W-1:0] idx
);
  localparam logic [WORD_W-1:0] LO_W = LO_WORD[WORD_W-1:0];
  localparam logic [WORD_W-1:0] HI_W = HI_WORD[WORD_W-1:0];
  localparam int TOP_WORD = (1 << WORD_W) - 1;

  logic lo_ok, hi_ok;

  assign lo_ok = (word >= LO_W);

  generate
    if (HI_WORD >= TOP_WORD) begin : g_hi_open
      assign hi_ok = 1'b1;
    end else begin : g_hi_cmp
      assign hi_ok = (word <= HI_W);
    end
  endgenerate

  assign in_win = lo_ok && hi_ok;
  assign idx    = word - LO_W;
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10,
  parameter int DEPTH  = 1004
) (
  input  logic              clk,
  input  logic              hw_en,
  input  logic [IDX_W-1:0]  hw_idx,
  input  logic [DATA_W-1:0] hw_data,
  input  logic              lw_en,
  input  logic [IDX_W-1:0]  lw_idx,
  input  logic [DATA_W-1:0] lw_data,
  input  logic [IDX_W-1:0]  hr_idx,
  output logic [DATA_W-1:0] hr_data,
  input  logic [IDX_W-1:0]  lr_idx,
  output logic [DATA_W-1:0] lr_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              lw_shadowed;

  // host write owns a word both sides target in one cycle
  assign lw_shadowed = hw_en && (hw_idx == lw_idx);

  always_ff @(posedge clk) begin
    if (lw_en && !lw_shadowed) mem[lw_idx] <= lw_data;
    if (hw_en)                 mem[hw_idx] <= hw_data;
  end

  assign hr_data = mem[hr_idx];
  assign lr_data = mem[lr_idx];
endmodule

// File: rtl/mbx_capture.sv
module mbx_capture #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              clr,
  input  logic              mask,
  output logic              stat,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              irq
);
  logic armed;
  assign armed = !stat || clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat     <= 1'b0;
      cap_addr <= '0;
    end else if (set) begin
      stat <= 1'b1;
      if (armed) cap_addr <= set_addr;
    end else if (clr) begin
      stat <= 1'b0;
    end
  end

  assign irq = stat && !mask;
endmodule

// File: rtl/mbx_rsp.sv
module mbx_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rready,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              can_take
);
  assign can_take = !rvalid || rready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (load) begin
      rvalid <= 1'b1;
      rdata  <= load_data;
    end else if (rready) begin
      rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/mbx_index_mailbox.sv
module mbx_index_mailbox #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int WIN_LO  = 'h050,
  parameter int WIN_HI  = 'hFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic              h_rvalid,
  input  logic              h_rready,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-3:0] l_word,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              stat_w1c,
  input  logic              irq_mask,
  output logic              irq_status,
  output logic [ADDR_W-1:0] idx_addr,
  output logic              irq
);
  import mbx_pkg::*;

  localparam int WORD_W  = ADDR_W - 2;
  localparam int LO_WORD = WIN_LO / 4;
  localparam int HI_WORD = WIN_HI / 4;
  localparam int DEPTH   = HI_WORD - LO_WORD + 1;

  logic              h_in_win, l_in_win;
  logic [WORD_W-1:0] h_idx, l_idx;
  logic              h_take, h_aligned;
  hop_e              hop;
  logic [DATA_W-1:0] hr_word, lr_word, h_fetch;
  logic              lw_en, lr_en;

  mbx_decode #(.WORD_W(WORD_W), .LO_WORD(LO_WORD), .HI_WORD(HI_WORD)) u_hdec (
    .word(h_addr[ADDR_W-1:2]), .in_win(h_in_win), .idx(h_idx)
  );

  mbx_decode #(.WORD_W(WORD_W), .LO_WORD(LO_WORD), .HI_WORD(HI_WORD)) u_ldec (
    .word(l_word), .in_win(l_in_win), .idx(l_idx)
  );

  assign h_take    = h_valid && h_ready;
  assign h_aligned = (h_addr[1:0] == 2'b00);
  assign hop       = classify(h_take, h_write, h_aligned, h_in_win);
  assign lw_en     = l_en && l_we && l_in_win;
  assign lr_en     = l_en && !l_we;

  mbx_store #(.DATA_W(DATA_W), .IDX_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .hw_en   (hop == HOP_STORE),
    .hw_idx  (h_idx),
    .hw_data (h_wdata),
    .lw_en   (lw_en),
    .lw_idx  (l_idx),
    .lw_data (l_wdata),
    .hr_idx  (h_idx),
    .hr_data (hr_word),
    .lr_idx  (l_idx),
    .lr_data (lr_word)
  );

  assign h_fetch = h_in_win ? hr_word : '0;

  mbx_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (hop == HOP_FETCH),
    .load_data (h_fetch),
    .rready    (h_rready),
    .rvalid    (h_rvalid),
    .rdata     (h_rdata),
    .can_take  (h_ready)
  );

  mbx_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (hop == HOP_STORE),
    .set_addr (h_addr),
    .clr      (stat_w1c),
    .mask     (irq_mask),
    .stat     (irq_status),
    .cap_addr (idx_addr),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     l_rdata <= '0;
    else if (lr_en) l_rdata <= l_in_win ? lr_word : '0;
  end
endmodule

// File: rtl/mbx_index_mailbox_chk.sv
module mbx_index_mailbox_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int WIN_LO = 'h050,
  parameter int WIN_HI = 'hFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_valid,
  input logic              h_ready,
  input logic              h_write,
  input logic [ADDR_W-1:0] h_addr,
  input logic              h_rvalid,
  input logic              h_rready,
  input logic [DATA_W-1:0] h_rdata,
  input logic              l_en,
  input logic              l_we,
  input logic              stat_w1c,
  input logic              irq_mask,
  input logic              irq_status,
  input logic [ADDR_W-1:0] idx_addr,
  input logic              irq
);
  logic win_hit, good_wr, bad_wr;
  assign win_hit = (int'(h_addr[ADDR_W-1:2]) >= WIN_LO / 4) &&
                   (int'(h_addr[ADDR_W-1:2]) <= WIN_HI / 4);
  assign good_wr = h_valid && h_ready && h_write && (h_addr[1:0] == 2'b00) && win_hit;
  assign bad_wr  = h_valid && h_ready && h_write && !((h_addr[1:0] == 2'b00) && win_hit);

  AST_SET_ON_HOST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr |=> irq_status); // R2
  AST_CAPTURE_WHEN_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr && (!irq_status || stat_w1c) |=> idx_addr == $past(h_addr)); // R3
  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status && !stat_w1c |=> $stable(idx_addr)); // R4
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status && stat_w1c && !good_wr |=> !irq_status); // R5
  AST_LOCAL_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    l_en && l_we && !good_wr && !irq_status |=> !irq_status); // R6
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq); // R7
  AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_status); // R7
  AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr && !irq_status |=> !irq_status); // R8
  AST_NO_CAPTURE_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !good_wr |=> $stable(idx_addr)); // R6
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid && !h_rready |=> h_rvalid && $stable(h_rdata)); // R10
  AST_READY_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid && !h_rready |-> !h_ready); // R10
endmodule

bind mbx_index_mailbox mbx_index_mailbox_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
  .h_write(h_write), .h_addr(h_addr), .h_rvalid(h_rvalid),
  .h_rready(h_rready), .h_rdata(h_rdata), .l_en(l_en), .l_we(l_we),
  .stat_w1c(stat_w1c), .irq_mask(irq_mask), .irq_status(irq_status),
  .idx_addr(idx_addr), .irq(irq)
);

// File: tb/sim_mbx_index_mailbox.sv
module sim_mbx_index_mailbox;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        h_valid, h_write, h_rready;
  logic [11:0] h_addr;
  logic [31:0] h_wdata;
  logic        h_ready, h_rvalid;
  logic [31:0] h_rdata;
  logic        l_en, l_we;
  logic [9:0]  l_word;
  logic [31:0] l_wdata, l_rdata;
  logic        stat_w1c, irq_mask;
  logic        irq_status, irq;
  logic [11:0] idx_addr;

  always #5 clk = ~clk;

  mbx_index_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
    .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rvalid(h_rvalid), .h_rready(h_rready), .h_rdata(h_rdata),
    .l_en(l_en), .l_we(l_we), .l_word(l_word), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .stat_w1c(stat_w1c), .irq_mask(irq_mask),
    .irq_status(irq_status), .idx_addr(idx_addr), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference
  int          m_mem [int];
  bit          m_stat;
  logic [11:0] m_idx;
  bit          m_rv, m_rd_known, m_ld_known;
  logic [31:0] m_rd, m_ld;

  function automatic bit in_win(int w);
    return (w >= 20) && (w <= 1023);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_idx = '0; m_rv = 0; m_rd = '0; m_rd_known = 1;
      m_ld = '0; m_ld_known = 1;
    end else begin
      automatic bit hacc = h_valid && (!m_rv || h_rready);
      automatic int hw   = int'(h_addr[11:2]);
      automatic bit hok  = hacc && h_write && (h_addr[1:0] == 0) && in_win(hw);
      automatic bit lok  = l_en && l_we && in_win(int'(l_word));
      if (hacc && !h_write) begin
        m_rv = 1;
        if (!in_win(hw))          begin m_rd = '0; m_rd_known = 1; end
        else if (m_mem.exists(hw)) begin m_rd = m_mem[hw]; m_rd_known = 1; end
        else m_rd_known = 0;
      end else if (m_rv && h_rready) m_rv = 0;
      if (l_en && !l_we) begin
        if (!in_win(int'(l_word)))          begin m_ld = '0; m_ld_known = 1; end
        else if (m_mem.exists(int'(l_word))) begin m_ld = m_mem[int'(l_word)]; m_ld_known = 1; end
        else m_ld_known = 0;
      end
      if (lok) m_mem[int'(l_word)] = l_wdata;
      if (hok) m_mem[hw] = h_wdata;      // host wins a same-word collision (R9)
      if (hok) begin
        if (!m_stat || stat_w1c) m_idx = h_addr;
        m_stat = 1;
      end else if (stat_w1c) m_stat = 0;
    end
  end

  // compare every cycle, mid-period
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(irq_status === m_stat, "R2 status", 32'(irq_status), 32'(m_stat));
      chk(idx_addr === m_idx, "R3 idx_addr", 32'(idx_addr), 32'(m_idx));
      chk(irq === (m_stat && !irq_mask), "R7 irq", 32'(irq), 32'(m_stat && !irq_mask));
      chk(h_ready === (!m_rv || h_rready), "R10 h_ready", 32'(h_ready), 32'(!m_rv || h_rready));
      chk(h_rvalid === m_rv, "R10 h_rvalid", 32'(h_rvalid), 32'(m_rv));
      if (m_rv && m_rd_known) chk(h_rdata === m_rd, "R1 h_rdata", h_rdata, m_rd);
      if (m_ld_known) chk(l_rdata === m_ld, "R12 l_rdata", l_rdata, m_ld);
    end
  end

  task automatic quiet();
    h_valid = 0; h_write = 0; h_addr = '0; h_wdata = '0; h_rready = 1;
    l_en = 0; l_we = 0; l_word = '0; l_wdata = '0; stat_w1c = 0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic host_wr(logic [11:0] a, logic [31:0] d);
    h_valid = 1; h_write = 1; h_addr = a; h_wdata = d; tick(); quiet();
  endtask

  task automatic host_rd(logic [11:0] a);
    h_valid = 1; h_write = 0; h_addr = a; tick(); quiet();
  endtask

  task automatic loc_rd(logic [9:0] w);
    l_en = 1; l_we = 0; l_word = w; tick(); quiet();
  endtask

  task automatic loc_wr(logic [9:0] w, logic [31:0] d);
    l_en = 1; l_we = 1; l_word = w; l_wdata = d; tick(); quiet();
  endtask

  task automatic clear_stat();
    stat_w1c = 1; tick(); quiet();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      summary();
      $finish;
    end
  end

  initial begin
    quiet(); irq_mask = 0; rst_n = 0;
    repeat (3) tick();
    rst_n = 1; tick();
    // R11: reset values
    chk(irq_status === 0 && idx_addr === 0 && irq === 0, "R11 status/idx/irq", {19'd0, irq_status, idx_addr}, 32'd0);
    chk(h_rvalid === 0 && l_rdata === 0, "R11 rsp/l_rdata", l_rdata, 32'd0);

    host_wr(12'h050, 32'hA5A5_0001);               // R2 R3 first word
    chk(irq_status === 1 && idx_addr === 12'h050, "R3 capture", 32'(idx_addr), 32'h050);
    host_wr(12'h100, 32'h1111_2222);
    chk(idx_addr === 12'h050, "R4 frozen", 32'(idx_addr), 32'h050);
    loc_rd(10'h040);
    chk(l_rdata === 32'h1111_2222, "R12 local read", l_rdata, 32'h1111_2222);

    // R10 back-pressure
    h_valid = 1; h_write = 0; h_addr = 12'h050; tick();
    h_valid = 0; h_rready = 0; tick(); tick();
    chk(h_rvalid === 1 && h_rdata === 32'hA5A5_0001, "R10 held", h_rdata, 32'hA5A5_0001);
    chk(h_ready === 0, "R10 ready low", 32'(h_ready), 32'd0);
    quiet(); tick();

    clear_stat();
    chk(irq_status === 0, "R5 clear", 32'(irq_status), 32'd0);
    host_wr(12'h200, 32'h0000_0200);
    chk(idx_addr === 12'h200, "R5 rearm", 32'(idx_addr), 32'h200);
    stat_w1c = 1; host_wr(12'h300, 32'h0000_0300);
    chk(irq_status === 1 && idx_addr === 12'h300, "R5 set wins", 32'(idx_addr), 32'h300);

    clear_stat();
    loc_wr(10'h100, 32'hBEEF_0400);
    chk(irq_status === 0 && idx_addr === 12'h300, "R6 local write inert", 32'(idx_addr), 32'h300);
    host_rd(12'h400); tick();
    chk(h_rdata === 32'hBEEF_0400, "R1 local data seen by host", h_rdata, 32'hBEEF_0400);

    irq_mask = 1; host_wr(12'h500, 32'h5);
    chk(irq === 0 && irq_status === 1 && idx_addr === 12'h500, "R7 mask", 32'(idx_addr), 32'h500);
    irq_mask = 0; clear_stat();

    host_wr(12'h04C, 32'hDEAD);
    host_wr(12'h502, 32'hDEAD);
    chk(irq_status === 0 && idx_addr === 12'h500, "R8 dropped writes", 32'(irq_status), 32'd0);
    host_rd(12'h500); tick();
    chk(h_rdata === 32'h5, "R8 unaligned write no store", h_rdata, 32'h5);
    host_rd(12'h010); tick();
    chk(h_rdata === 32'h0, "R8 outside read zero", h_rdata, 32'h0);
    host_wr(12'hFFC, 32'h7777_0FFC);
    chk(idx_addr === 12'hFFC, "R1 top word", 32'(idx_addr), 32'hFFC);

    clear_stat();
    h_valid = 1; h_write = 1; h_addr = 12'h600; h_wdata = 32'hC0DE_0001;
    l_en = 1; l_we = 1; l_word = 10'h180; l_wdata = 32'hC0DE_0002;
    tick(); quiet();
    loc_rd(10'h180);
    chk(l_rdata === 32'hC0DE_0001, "R9 host wins", l_rdata, 32'hC0DE_0001);

    for (int i = 0; i < 4000; i++) begin
      automatic int sel = $urandom_range(0, 9);
      h_valid  = ($urandom_range(0, 1) == 1);
      h_write  = ($urandom_range(0, 1) == 1);
      h_addr   = (sel == 0) ? 12'hFFC : (sel == 1) ? 12'(($urandom_range(18, 40) << 2) | 1)
                                      : 12'($urandom_range(18, 40) << 2);
      h_wdata  = $urandom;
      h_rready = ($urandom_range(0, 9) < 7);
      l_en     = ($urandom_range(0, 9) < 4);
      l_we     = ($urandom_range(0, 1) == 1);
      l_word   = 10'($urandom_range(18, 40));
      l_wdata  = $urandom;
      stat_w1c = ($urandom_range(0, 9) < 2);
      irq_mask = ($urandom_range(0, 9) < 2);
      tick();
    end
    quiet(); tick(); tick();

    finished = 1;
    summary();
    $finish;
  end
endmodule